// File: doc/BRIEF.md
# Bit-Band Alias Bus Translator

The translator sits between a bus master and a byte-addressable memory port. Some address ranges are alias windows, each 32 MB long. Inside a window every 32-bit alias word stands for one bit of a smaller underlying region. Two windows are built in:

| Alias window | Underlying region |
|---|---|
| `0x2200_0000` | `0x2000_0000` |
| `0x4200_0000` | `0x4000_0000` |

A read of an alias word fetches the containing data from memory and returns only the selected bit. A write of an alias word changes only that bit. It does this as a read-modify-write: it fetches the access-sized aligned data, sets or clears the one bit, and writes the data back.

The slave side accepts one request at a time and stays not-ready until the master has taken the response. This means two read-modify-write sequences can never overlap. Both ports use valid/ready handshakes. Memory errors are passed back to the master, and a failed fetch cancels the write-back.

Top module: `bitband_xlate`

## Requirements
- R1: For an accepted alias access at address A, the memory request address is the window's underlying base OR (A[24:0] >> 5), rounded down to a multiple of the access size. The memory request carries the same size code as the slave request. A pending memory request holds its fields until it is accepted.
- R2: Window 0 (A[31:25] equal to `0x2200_0000` >> 25) maps to `0x2000_0000`. Window 1 (`0x4200_0000`) maps to `0x4000_0000`. Each window decodes independently.
- R3: A successful alias read responds with the selected bit in bit 0 of `s_rsp_rdata`, all other bits zero, and `s_rsp_err` low. No response ever carries a nonzero bit above bit 0.
- R4: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The bit index is (A >> 2) AND (8 × bytes − 1). Memory data is little-endian in the low lanes: byte k of the fetched data sits in bits [8k+7:8k], so index i is data bit i.
- R5: An alias write fetches the aligned data, sets the selected bit if `s_req_wdata[0]` is 1 and clears it otherwise, then writes the data back to the same address and size. All other bits are unchanged.
- R6: If the memory fetch reports an error, the translator responds at once with `s_rsp_err` high and data zero, and issues no write-back.
- R7: The response to an alias write carries the error status of the write-back.
- R8: An address outside both windows, or size code 3, gets an error response with data zero and causes no memory access.
- R9: `s_req_ready` is low from the cycle after a request is accepted until the response has been taken. No memory request is raised while `s_req_ready` is high.
- R10: While and just after synchronous reset, `s_req_ready` is high and `s_rsp_valid` and `m_req_valid` are low.
- R11: A response that is not accepted stays valid with stable data and error until `s_rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req_valid | input | 1 | Slave request valid |
| s_req_ready | output | 1 | Slave request ready |
| s_req_addr | input | 32 | Alias address |
| s_req_write | input | 1 | 1 = write, 0 = read |
| s_req_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| s_req_wdata | input | 32 | Write data; only bit 0 is used |
| s_rsp_valid | output | 1 | Slave response valid |
| s_rsp_ready | input | 1 | Slave response ready |
| s_rsp_rdata | output | 32 | Read bit in bit 0 |
| s_rsp_err | output | 1 | Response error |
| m_req_valid | output | 1 | Memory request valid |
| m_req_ready | input | 1 | Memory request ready |
| m_req_addr | output | 32 | Aligned underlying byte address |
| m_req_write | output | 1 | Memory write |
| m_req_size | output | 2 | Memory size code |
| m_req_wdata | output | 32 | Write-back data, low lanes |
| m_rsp_valid | input | 1 | Memory response valid |
| m_rsp_ready | output | 1 | Memory response ready |
| m_rsp_rdata | input | 32 | Fetched data, low lanes |
| m_rsp_err | input | 1 | Memory error |

## Verification
Some properties are checked on every cycle:
- one transaction in flight at a time;
- response and memory-request stability under backpressure;
- the zero upper response bits;
- aligned memory addresses;
- no write-back after a failed fetch;
- the idle state after reset.

Other behaviour can only be shown by the bench scenarios against a reference image of memory:
- the address arithmetic for each window;
- the size-dependent bit index and byte lane;
- the fact that only the chosen bit changes;
- the status of the write-back;
- rejection of unmapped addresses and the illegal size.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int BB_ADDR_W  = 32;
    localparam int BB_DATA_W  = 32;
    localparam int BB_WIN_LSB = 25;
    localparam int BB_IDX_W   = $clog2(BB_DATA_W);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_RESP
    } bb_state_t;

    typedef struct packed {
        logic [BB_ADDR_W-1:0] target;
        logic [BB_IDX_W-1:0]  idx;
        logic [1:0]           size;
        logic                 write;
        logic                 wval;
    } bb_xact_t;

    function automatic logic [BB_ADDR_W-1:0] bb_align(logic [BB_ADDR_W-1:0] a, logic [1:0] sz);
        case (sz)
            SZ_HALF: bb_align = {a[BB_ADDR_W-1:1], 1'b0};
            SZ_WORD: bb_align = {a[BB_ADDR_W-1:2], 2'b00};
            default: bb_align = a;
        endcase
    endfunction

    function automatic logic [BB_IDX_W-1:0] bb_index(logic [BB_IDX_W-1:0] word_sel, logic [1:0] sz);
        case (sz)
            SZ_BYTE: bb_index = word_sel & BB_IDX_W'(7);
            SZ_HALF: bb_index = word_sel & BB_IDX_W'(15);
            default: bb_index = word_sel;
        endcase
    endfunction

    function automatic logic [BB_DATA_W-1:0] bb_lane_mask(logic [1:0] sz);
        case (sz)
            SZ_BYTE: bb_lane_mask = BB_DATA_W'(8'hFF);
            SZ_HALF: bb_lane_mask = BB_DATA_W'(16'hFFFF);
            default: bb_lane_mask = '1;
        endcase
    endfunction
endpackage

// File: rtl/bb_win_decode.sv
module bb_win_decode
    import bb_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [BB_ADDR_W-1:0] addr,
    input  logic [1:0]           size,
    output logic                 hit,
    output logic [BB_ADDR_W-1:0] target,
    output logic [BB_IDX_W-1:0]  idx
);
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [NUM_WIN-1:0]   match;
    logic [BB_ADDR_W-1:0] tbase [NUM_WIN];
    logic [SEL_W-1:0]     sel;
    logic                 any_match;
    logic [BB_ADDR_W-1:0] raw;
    logic [1:0]           unused_lo;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign match[w] = (addr[BB_ADDR_W-1:BB_WIN_LSB] ==
                           ALIAS_BASES[w*BB_ADDR_W+BB_WIN_LSB +: BB_ADDR_W-BB_WIN_LSB]);
        assign tbase[w] = TARGET_BASES[w*BB_ADDR_W +: BB_ADDR_W];
    end

    always_comb begin
        any_match = 1'b0;
        sel       = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (match[w]) begin
                any_match = 1'b1;
                sel       = SEL_W'(w);
            end
        end
    end

    assign raw       = tbase[sel] | BB_ADDR_W'(addr[BB_WIN_LSB-1:5]);
    assign target    = bb_align(raw, size);
    assign idx       = bb_index(addr[BB_IDX_W+1:2], size);
    assign hit       = any_match && (size != 2'd3);
    assign unused_lo = addr[1:0];
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bb_pkg::*;
(
    input  logic [BB_DATA_W-1:0] rdata,
    input  logic [BB_IDX_W-1:0]  idx,
    input  logic [1:0]           size,
    input  logic                 set_val,
    output logic                 bit_val,
    output logic [BB_DATA_W-1:0] merged
);
    logic [BB_DATA_W-1:0] onehot;

    assign onehot  = BB_DATA_W'(1) << idx;
    assign bit_val = rdata[idx];
    assign merged  = (set_val ? (rdata | onehot) : (rdata & ~onehot)) & bb_lane_mask(size);
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
    import bb_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_req_valid,
    output logic                 s_req_ready,
    input  logic [BB_ADDR_W-1:0] s_req_addr,
    input  logic                 s_req_write,
    input  logic [1:0]           s_req_size,
    input  logic [BB_DATA_W-1:0] s_req_wdata,
    output logic                 s_rsp_valid,
    input  logic                 s_rsp_ready,
    output logic [BB_DATA_W-1:0] s_rsp_rdata,
    output logic                 s_rsp_err,
    output logic                 m_req_valid,
    input  logic                 m_req_ready,
    output logic [BB_ADDR_W-1:0] m_req_addr,
    output logic                 m_req_write,
    output logic [1:0]           m_req_size,
    output logic [BB_DATA_W-1:0] m_req_wdata,
    input  logic                 m_rsp_valid,
    output logic                 m_rsp_ready,
    input  logic [BB_DATA_W-1:0] m_rsp_rdata,
    input  logic                 m_rsp_err
);
    bb_state_t            st;
    bb_xact_t             xact;
    logic [BB_DATA_W-1:0] wb_data;
    logic [BB_DATA_W-1:0] rsp_data;
    logic                 rsp_err;

    logic                 dec_hit;
    logic [BB_ADDR_W-1:0] dec_target;
    logic [BB_IDX_W-1:0]  dec_idx;
    logic                 sel_bit;
    logic [BB_DATA_W-1:0] merged;
    logic [BB_DATA_W-2:0] unused_wdata;

    assign unused_wdata = s_req_wdata[BB_DATA_W-1:1];

    bb_win_decode #(
        .NUM_WIN(NUM_WIN), .ALIAS_BASES(ALIAS_BASES), .TARGET_BASES(TARGET_BASES)
    ) dec_i (
        .addr(s_req_addr), .size(s_req_size),
        .hit(dec_hit), .target(dec_target), .idx(dec_idx)
    );

    bb_bit_merge merge_i (
        .rdata(m_rsp_rdata), .idx(xact.idx), .size(xact.size), .set_val(xact.wval),
        .bit_val(sel_bit), .merged(merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            xact     <= '0;
            wb_data  <= '0;
            rsp_data <= '0;
            rsp_err  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (s_req_valid) begin
                    xact.target <= dec_target;
                    xact.idx    <= dec_idx;
                    xact.size   <= s_req_size;
                    xact.write  <= s_req_write;
                    xact.wval   <= s_req_wdata[0];
                    if (dec_hit) begin
                        st <= ST_RD_REQ;
                    end else begin
                        rsp_data <= '0;
                        rsp_err  <= 1'b1;
                        st       <= ST_RESP;
                    end
                end
                ST_RD_REQ: if (m_req_ready) st <= ST_RD_WAIT;
                ST_RD_WAIT: if (m_rsp_valid) begin
                    if (m_rsp_err) begin
                        rsp_data <= '0;
                        rsp_err  <= 1'b1;
                        st       <= ST_RESP;
                    end else if (xact.write) begin
                        wb_data <= merged;
                        st      <= ST_WR_REQ;
                    end else begin
                        rsp_data <= BB_DATA_W'(sel_bit);
                        rsp_err  <= 1'b0;
                        st       <= ST_RESP;
                    end
                end
                ST_WR_REQ: if (m_req_ready) st <= ST_WR_WAIT;
                ST_WR_WAIT: if (m_rsp_valid) begin
                    rsp_data <= '0;
                    rsp_err  <= m_rsp_err;
                    st       <= ST_RESP;
                end
                ST_RESP: if (s_rsp_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign s_req_ready = (st == ST_IDLE);
    assign s_rsp_valid = (st == ST_RESP);
    assign s_rsp_rdata = rsp_data;
    assign s_rsp_err   = rsp_err;
    assign m_req_valid = (st == ST_RD_REQ) || (st == ST_WR_REQ);
    assign m_req_write = (st == ST_WR_REQ);
    assign m_req_addr  = xact.target;
    assign m_req_size  = xact.size;
    assign m_req_wdata = (st == ST_WR_REQ) ? wb_data : '0;
    assign m_rsp_ready = (st == ST_RD_WAIT) || (st == ST_WR_WAIT);
endmodule

// File: rtl/bitband_xlate_chk.sv
module bitband_xlate_chk
    import bb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 s_req_valid,
    input logic                 s_req_ready,
    input logic                 s_rsp_valid,
    input logic                 s_rsp_ready,
    input logic [BB_DATA_W-1:0] s_rsp_rdata,
    input logic                 s_rsp_err,
    input logic                 m_req_valid,
    input logic                 m_req_ready,
    input logic                 m_req_write,
    input logic [BB_ADDR_W-1:0] m_req_addr,
    input logic [1:0]           m_req_size,
    input logic                 m_rsp_valid,
    input logic                 m_rsp_ready,
    input logic                 m_rsp_err
);
    logic last_was_rd;

    always_ff @(posedge clk) begin
        if (rst) last_was_rd <= 1'b0;
        else if (m_req_valid && m_req_ready) last_was_rd <= !m_req_write;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (s_req_ready && !s_rsp_valid && !m_req_valid)); // R10
    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (s_req_valid && s_req_ready) |=> !s_req_ready); // R9
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        s_req_ready |-> !m_req_valid); // R9
    AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
        (s_rsp_valid && !s_rsp_ready) |=> (s_rsp_valid && $stable(s_rsp_rdata) && $stable(s_rsp_err))); // R11
    AST_RSP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        s_rsp_valid |-> (s_rsp_rdata[BB_DATA_W-1:1] == '0)); // R3
    AST_MREQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        m_req_valid |-> ((m_req_size == SZ_BYTE) ||
                         (m_req_size == SZ_HALF && !m_req_addr[0]) ||
                         (m_req_size == SZ_WORD && m_req_addr[1:0] == 2'b00))); // R1
    AST_MREQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (m_req_valid && !m_req_ready) |=> (m_req_valid && $stable(m_req_addr) && $stable(m_req_write))); // R1
    AST_NO_WB_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
        (m_rsp_valid && m_rsp_ready && m_rsp_err && last_was_rd) |=> (!m_req_valid && s_rsp_valid && s_rsp_err)); // R6
endmodule

bind bitband_xlate bitband_xlate_chk chk_i (.*);

// File: tb/bitband_xlate_tb_top.sv
module bitband_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        s_req_valid, s_req_ready, s_req_write;
    logic [31:0] s_req_addr, s_req_wdata;
    logic [1:0]  s_req_size;
    logic        s_rsp_valid, s_rsp_ready, s_rsp_err;
    logic [31:0] s_rsp_rdata;
    logic        m_req_valid, m_req_ready, m_req_write;
    logic [31:0] m_req_addr, m_req_wdata;
    logic [1:0]  m_req_size;
    logic        m_rsp_valid, m_rsp_ready, m_rsp_err;
    logic [31:0] m_rsp_rdata;

    int errors = 0;
    int checks = 0;

    logic [7:0] mem    [2][256];
    logic [7:0] refmem [2][256];
    logic       inj_rd, inj_wr;
    int         rd_cnt, wr_cnt;
    logic [31:0] last_rd_addr, last_wr_addr;
    logic [1:0]  last_rd_size, last_wr_size;

    always #10 clk = ~clk;

    bitband_xlate dut_i (.*);

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_target(logic [31:0] a, logic [1:0] sz);
        logic [31:0] base = a[30] ? 32'h4000_0000 : 32'h2000_0000;
        logic [31:0] t = base | ((a & 32'h01FF_FFFF) >> 5);
        return t & ~((32'd1 << sz) - 32'd1);
    endfunction

    function automatic int exp_idx(logic [31:0] a, logic [1:0] sz);
        return int'((a >> 2) & ((32'd8 << sz) - 32'd1));
    endfunction

    // memory responder
    initial begin
        m_req_ready = 0; m_rsp_valid = 0; m_rsp_err = 0; m_rsp_rdata = 0;
        rd_cnt = 0; wr_cnt = 0;
        forever begin
            @(negedge clk);
            if (m_req_valid && !rst) begin
                logic [31:0] a, wd;
                logic        w;
                int          n, win;
                repeat ($urandom % 3) @(negedge clk);
                a = m_req_addr; w = m_req_write; wd = m_req_wdata;
                n = 1 << m_req_size; win = a[30] ? 1 : 0;
                m_req_ready = 1;
                @(negedge clk);
                m_req_ready = 0;
                m_rsp_rdata = 0;
                if (w) begin
                    wr_cnt++; last_wr_addr = a; last_wr_size = 2'(n >> 1);
                    m_rsp_err = inj_wr;
                    if (!inj_wr)
                        for (int k = 0; k < n; k++) mem[win][int'(a[7:0]) + k] = wd[8*k +: 8];
                end else begin
                    rd_cnt++; last_rd_addr = a; last_rd_size = (n == 4) ? 2'd2 : 2'(n >> 1);
                    m_rsp_err = inj_rd;
                    if (inj_rd) m_rsp_rdata = $urandom;
                    else for (int k = 0; k < n; k++) m_rsp_rdata[8*k +: 8] = mem[win][int'(a[7:0]) + k];
                end
                repeat ($urandom % 3) @(negedge clk);
                m_rsp_valid = 1;
                @(negedge clk);
                m_rsp_valid = 0; m_rsp_err = 0;
            end
        end
    end

    task automatic do_op(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                         input logic wv, input int hold, input logic irr, input logic iwr,
                         input logic exp_hit);
        int          rc0, wc0, idx, win, byte_i;
        logic [31:0] tgt, rdat, hold_d;
        logic        rerr, hold_e, rbit;
        rc0 = rd_cnt; wc0 = wr_cnt;
        inj_rd = irr; inj_wr = iwr;
        tgt = exp_target(a, sz); idx = exp_idx(a, sz); win = a[30] ? 1 : 0;
        byte_i = int'(tgt[7:0]) + (idx >> 3);
        @(negedge clk);
        while (!s_req_ready) @(negedge clk);
        s_req_valid = 1; s_req_addr = a; s_req_write = wr; s_req_size = sz;
        s_req_wdata = {$urandom, 1'b0} | {31'd0, wv};
        @(negedge clk);
        s_req_valid = 0;
        s_rsp_ready = (hold == 0);
        while (!s_rsp_valid) @(negedge clk);
        hold_d = s_rsp_rdata; hold_e = s_rsp_err;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk(s_rsp_valid && s_rsp_rdata == hold_d && s_rsp_err == hold_e, "R11 held response",
                {s_rsp_rdata[30:0], s_rsp_valid}, {hold_d[30:0], 1'b1});
            s_rsp_ready = 1;
        end
        rdat = s_rsp_rdata; rerr = s_rsp_err;
        @(negedge clk);
        if (!exp_hit) begin
            chk(rerr && rdat == 0, "R8 unmapped/illegal error", {31'd0, rerr}, 32'd1);
            chk(rd_cnt == rc0 && wr_cnt == wc0, "R8 no memory access", rd_cnt + wr_cnt - rc0 - wc0, 0);
            return;
        end
        chk(rd_cnt == rc0 + 1 && last_rd_addr == tgt, "R1 R2 fetch address", last_rd_addr, tgt);
        chk(last_rd_size == sz, "R1 fetch size", {30'd0, last_rd_size}, {30'd0, sz});
        if (irr) begin
            chk(rerr && rdat == 0, "R6 fetch error returned", {31'd0, rerr}, 32'd1);
            chk(wr_cnt == wc0, "R6 no write-back", wr_cnt - wc0, 0);
        end else if (!wr) begin
            rbit = refmem[win][byte_i][idx & 7];
            chk(!rerr && rdat == {31'd0, rbit}, "R3 R4 read bit", rdat, {31'd0, rbit});
        end else begin
            chk(wr_cnt == wc0 + 1 && last_wr_addr == tgt && last_wr_size == sz, "R5 write-back address",
                last_wr_addr, tgt);
            chk(rerr == iwr && rdat == 0, "R7 write status", {31'd0, rerr}, {31'd0, iwr});
            if (!iwr) refmem[win][byte_i][idx & 7] = wv;
            for (int k = 0; k < 4; k++)
                chk(mem[win][int'(tgt[7:0]) + k] == refmem[win][int'(tgt[7:0]) + k], "R5 R4 memory image",
                    {24'd0, mem[win][int'(tgt[7:0]) + k]}, {24'd0, refmem[win][int'(tgt[7:0]) + k]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; s_req_valid = 0; s_req_addr = 0; s_req_write = 0; s_req_size = 0;
        s_req_wdata = 0; s_rsp_ready = 1; inj_rd = 0; inj_wr = 0;
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 256; i++) begin
                mem[w][i] = 8'($urandom); refmem[w][i] = mem[w][i];
            end
        repeat (3) @(negedge clk);
        chk(s_req_ready && !s_rsp_valid && !m_req_valid, "R10 reset state",
            {29'd0, s_req_ready, s_rsp_valid, m_req_valid}, 32'h4);
        rst = 0;
        @(negedge clk);
        chk(s_req_ready && !s_rsp_valid && !m_req_valid, "R10 after reset",
            {29'd0, s_req_ready, s_rsp_valid, m_req_valid}, 32'h4);
        // directed corners: top index per size, both windows
        do_op(32'h2200_007C, 1, 2'd2, 1, 0, 0, 0, 1);  // R4 word, index 31
        do_op(32'h2200_007C, 0, 2'd2, 0, 0, 0, 0, 1);
        do_op(32'h4200_003C, 1, 2'd1, 0, 0, 0, 0, 1);  // R4 half, index 15
        do_op(32'h4200_003C, 0, 2'd1, 0, 0, 0, 0, 1);
        do_op(32'h2200_1FFC, 1, 2'd0, 1, 0, 0, 0, 1);  // R4 byte, index 7
        do_op(32'h2200_1FFC, 0, 2'd0, 0, 3, 0, 0, 1);  // R11 hold
        do_op(32'h2400_0000, 0, 2'd0, 0, 0, 0, 0, 0);  // R8 outside
        do_op(32'h4200_0010, 1, 2'd3, 1, 0, 0, 0, 0);  // R8 size 3
        do_op(32'h4200_0100, 1, 2'd2, 1, 0, 1, 0, 1);  // R6
        do_op(32'h4200_0100, 0, 2'd2, 0, 0, 1, 0, 1);  // R6 read
        do_op(32'h2200_0044, 1, 2'd1, 1, 0, 0, 1, 1);  // R7
        do_op(32'h2200_0044, 0, 2'd1, 0, 0, 0, 0, 1);
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            a = ($urandom % 2 == 0 ? 32'h2200_0000 : 32'h4200_0000) | ($urandom & 32'h1FFF);
            do_op(a, 1'($urandom), 2'($urandom % 3), 1'($urandom), ($urandom % 8 == 0) ? 2 : 0,
                  ($urandom % 16 == 0), ($urandom % 16 == 0), 1);
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule